// File: doc/BRIEF.md
# Parallel ROM Read Sequencer

This block runs read cycles on an asynchronous parallel ROM from a synchronous host. The host presents a byte address and a size flag on a valid/ready request and receives the read value with a one-cycle valid strobe. On the memory side the block drives the address lines, active-low chip enable and output enable, and a width select. It samples a 16-bit data bus. In byte organisation the topmost data pin of the ROM becomes its least significant address input, so the block drives that pin only for byte reads and leaves it floating otherwise.

All wait counts come from parameters: the clock period and the three access times. The access length is the ceiling of the slowest applicable access time over the clock period, plus one cycle of margin. The data is registered on that final cycle, while the address and enables are still held.

A read that is followed at once by a read of the same size reuses the enabled memory without a gap. Any other ending deasserts both enables and waits out a bus release time before a new request is taken. This covers a size change, which flips the direction of the shared pin. While nothing is pending, chip enable stays high, which holds the ROM in standby.

States: `ST_IDLE` (standby, ready for a request), `ST_ACCESS` (enables low, address held, wait count running), `ST_RELEASE` (enables high, release count running). Transitions:
- IDLE to ACCESS on an accepted request.
- ACCESS to ACCESS on the capture cycle when a same-size request is accepted (chain).
- ACCESS to RELEASE on the capture cycle otherwise.
- RELEASE to IDLE when the release count expires.

Top module: `prom_read_ctrl`

## Requirements
- R1: Reset state: `mem_ce_n`=1, `mem_oe_n`=1, `mem_lsb_oe`=0, `mem_wide`=1, `rsp_valid`=0, `rsp_data`=0 and `req_ready`=1.
- R2: Outside an access, both `mem_ce_n` and `mem_oe_n` are 1. `mem_oe_n` is never 0 while `mem_ce_n` is 1.
- R3: Word read (`req_byte`=0):
  - `mem_wide`=1 and `mem_addr`=`req_addr[19:1]`; address bit 0 is ignored.
  - `mem_lsb_oe`=0.
  - `rsp_data` is all 16 bus bits.
- R4: Byte read (`req_byte`=1):
  - `mem_wide`=0, `mem_addr`=`req_addr[19:1]`, `mem_lsb_oe`=1 and `mem_lsb`=`req_addr[0]`.
  - `rsp_data`={8'h00, bus[7:0]}; bus bits 15:8 have no effect.
- R5: Access timing:
  - An access holds both enables low and the address stable for WAIT = ceil(max(tAA, tCE, tOE)/Tclk)+1 cycles.
  - The bus is sampled on the last of these cycles.
  - `rsp_valid` pulses for the single following cycle, and `rsp_data` holds its value until the next response.
- R6: After an access that is not chained, both enables stay high for ceil(tHZ/Tclk) cycles with `req_ready`=0. The block then returns to idle.
- R7: On the last access cycle, `req_ready`=1 exactly when `req_byte` equals the size of the running access. A request accepted then starts the next access in the following cycle, with the enables kept low.
- R8: A request whose size differs from the running access is not accepted on the last access cycle. It waits for the release period and the idle state.
- R9: `mem_lsb_oe` changes only in a cycle where `mem_oe_n` is 1 now or was 1 in the cycle before.
- R10: In idle, `req_ready`=1 and a valid request is accepted on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 20 | Byte address |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid | output | 1 | One-cycle strobe: `rsp_data` is new |
| rsp_data | output | 16 | Read value, zero-extended for byte reads |
| mem_addr | output | 19 | ROM word address lines |
| mem_lsb | output | 1 | Value for the shared pin used as lowest address in byte mode |
| mem_lsb_oe | output | 1 | Drive enable for the shared pin |
| mem_ce_n | output | 1 | ROM chip enable, active low |
| mem_oe_n | output | 1 | ROM output enable, active low |
| mem_wide | output | 1 | ROM width select, 1 = word organisation |
| mem_dq_i | input | 16 | ROM data bus as sampled |

## Verification
The hardest case to reach is a capture cycle on which a request is already waiting. The outcome depends on whether that request's size matches the running access, because `req_ready` then changes with `req_byte`. Both the chain and the forced release must occur.

The request list places zero-gap requests behind each other in same-size runs and in size flips, so these cycles come up often. The bench's ROM model returns junk until the address and enables have been steady for the full access time. A shortened wait count therefore shows up as wrong data rather than passing unseen.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_RELEASE = 2'd2
    } rd_state_e;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/prom_cycle_timer.sv
module prom_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R5: a loaded count is what the following cycle sees
    assert_timer_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

    // R5: without a load the count only moves down by one or rests at zero
    assert_timer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/prom_pin_map.sv
module prom_pin_map #(
    parameter int AW = 20
) (
    input  logic          active,
    input  logic [AW-1:0] addr,
    input  logic          byte_sel,
    output logic [AW-2:0] mem_addr,
    output logic          mem_lsb,
    output logic          mem_lsb_oe,
    output logic          mem_wide
);
    always_comb begin
        mem_addr   = addr[AW-1:1];
        mem_wide   = !byte_sel;
        mem_lsb    = byte_sel ? addr[0] : 1'b0;
        mem_lsb_oe = active && byte_sel;
    end

    // R3, R4: the shared pin is never driven while word width is selected
    always_comb begin
        assert_lsb_width_R4: assert (!(mem_lsb_oe && mem_wide));
    end

endmodule

// File: rtl/prom_data_capture.sv
module prom_data_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          byte_sel,
    input  logic [DW-1:0] bus,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);
    localparam int HW = DW / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_data <= byte_sel ? {{(DW-HW){1'b0}}, bus[HW-1:0]} : bus;
            end
        end
    end

    // R4: a byte result never carries upper bits
    assert_byte_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && byte_sel) |=> (rsp_data[DW-1:HW] == '0));

    // R5: response data stays put between strobes
    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rsp_data));

endmodule

// File: rtl/prom_read_ctrl.sv
module prom_read_ctrl
    import prom_rd_pkg::*;
#(
    parameter int AW            = 20,
    parameter int DW            = 16,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_ADDR_NS     = 70,
    parameter int T_CE_NS       = 70,
    parameter int T_OE_NS       = 30,
    parameter int T_HZ_NS       = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_byte,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-2:0] mem_addr,
    output logic          mem_lsb,
    output logic          mem_lsb_oe,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_wide,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int T_MAX    = int'(max3(T_ADDR_NS, T_CE_NS, T_OE_NS));
    localparam int WAIT_CYC = int'(ceil_div(T_MAX, CLK_PERIOD_NS)) + 1;
    localparam int HZ_RAW   = int'(ceil_div(T_HZ_NS, CLK_PERIOD_NS));
    localparam int TA_CYC   = (HZ_RAW < 1) ? 1 : HZ_RAW;
    localparam int CNT_MAX  = (WAIT_CYC > TA_CYC) ? WAIT_CYC : TA_CYC;
    localparam int CNT_W    = $clog2(CNT_MAX) + 1;
    localparam logic [CNT_W-1:0] WAIT_LD = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LD   = CNT_W'(TA_CYC - 1);

    rd_state_e        state_q, state_d;
    logic [AW-1:0]    addr_q;
    logic             byte_q;
    logic             latch_req;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_last;
    logic             capture;
    logic             in_access;

    // next-state and control decode
    always_comb begin
        state_d    = state_q;
        latch_req  = 1'b0;
        timer_load = 1'b0;
        timer_val  = '0;
        capture    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    latch_req  = 1'b1;
                    timer_load = 1'b1;
                    timer_val  = WAIT_LD;
                    state_d    = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (timer_last) begin
                    capture    = 1'b1;
                    timer_load = 1'b1;
                    if (req_valid && (req_byte == byte_q)) begin
                        latch_req = 1'b1;
                        timer_val = WAIT_LD;
                    end else begin
                        timer_val = TA_LD;
                        state_d   = ST_RELEASE;
                    end
                end
            end
            ST_RELEASE: begin
                if (timer_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and held request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            byte_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (latch_req) begin
                addr_q <= req_addr;
                byte_q <= req_byte;
            end
        end
    end

    // outputs
    always_comb begin
        in_access = (state_q == ST_ACCESS);
        mem_ce_n  = !in_access;
        mem_oe_n  = !in_access;
        req_ready = (state_q == ST_IDLE) ||
                    (in_access && timer_last && (req_byte == byte_q));
    end

    prom_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_last)
    );

    prom_pin_map #(.AW(AW)) u_pins (
        .active     (in_access),
        .addr       (addr_q),
        .byte_sel   (byte_q),
        .mem_addr   (mem_addr),
        .mem_lsb    (mem_lsb),
        .mem_lsb_oe (mem_lsb_oe),
        .mem_wide   (mem_wide)
    );

    prom_data_capture #(.DW(DW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .byte_sel  (byte_q),
        .bus       (mem_dq_i),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    // R2: output enable only inside chip enable
    assert_oe_inside_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ce_n);

    // R5: address and enables held through a running access
    assert_addr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_access && !timer_last) |=> ($stable(mem_addr) && !mem_ce_n && !mem_oe_n));

    // R5: a response only follows an enabled cycle
    assert_rsp_after_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));

    // R6: no request taken at the start of the release period
    assert_release_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> !req_ready);

    // R9: shared pin turns only with outputs disabled
    assert_pin_turn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_lsb_oe) |-> (mem_oe_n || $past(mem_oe_n)));

endmodule

// File: tb/tb_prom_read_ctrl.sv
module tb_prom_read_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TAA = 70, TCE = 70, TOE = 30, THZ = 20;
    localparam int TMAX     = (TAA > TCE ? (TAA > TOE ? TAA : TOE) : (TCE > TOE ? TCE : TOE));
    localparam int ACC_NEED = (TMAX + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int WAIT_N   = ACC_NEED + 1;
    localparam int TA_N     = (THZ + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int NREQ_MAX = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic        req_byte = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [18:0] mem_addr;
    logic        mem_lsb, mem_lsb_oe, mem_ce_n, mem_oe_n, mem_wide;
    logic [15:0] mem_dq_i;

    prom_read_ctrl #(
        .CLK_PERIOD_NS(CLK_PERIOD), .T_ADDR_NS(TAA), .T_CE_NS(TCE),
        .T_OE_NS(TOE), .T_HZ_NS(THZ)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_lsb(mem_lsb),
        .mem_lsb_oe(mem_lsb_oe), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_wide(mem_wide), .mem_dq_i(mem_dq_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] rom_word(input logic [18:0] wa);
        logic [31:0] p;
        p = {13'b0, wa} * 32'd40503;
        return p[15:0] ^ 16'h3C5A ^ {wa[18:16], 13'b0};
    endfunction

    // behavioural ROM: junk until the pins have been steady for the access time
    logic [24:0] key, key_q;
    int          hold_cnt;
    logic [15:0] rom_w;
    assign key = {mem_addr, mem_lsb, mem_lsb_oe, mem_wide, mem_ce_n, mem_oe_n};

    always @(posedge clk) begin
        if (key != key_q || mem_ce_n || mem_oe_n) hold_cnt <= 0;
        else if (hold_cnt < 1000) hold_cnt <= hold_cnt + 1;
        key_q <= key;
    end

    always_comb begin
        rom_w = rom_word(mem_addr);
        if (mem_ce_n || mem_oe_n || key != key_q || hold_cnt < ACC_NEED - 1)
            mem_dq_i = 16'hBEEF;
        else if (!mem_wide)
            mem_dq_i = mem_lsb_oe ? {8'h5A, (mem_lsb ? rom_w[15:8] : rom_w[7:0])} : 16'hBEEF;
        else
            mem_dq_i = rom_w;
    end

    // reference model, advanced on every rising edge
    int          m_phase;   // 0 idle, 1 access, 2 release
    int          m_cnt;
    logic [19:0] m_addr;
    logic        m_byte;
    logic        e_valid;
    logic [15:0] e_data;
    logic        m_accept;

    function automatic logic model_ready();
        return (m_phase == 0) || (m_phase == 1 && m_cnt == 1 && req_byte == m_byte);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_addr = '0; m_byte = 1'b0;
            e_valid = 1'b0; e_data = '0; m_accept = 1'b0;
        end else begin
            logic rdy;
            logic [15:0] w;
            rdy = model_ready();
            m_accept = req_valid && rdy;
            e_valid = 1'b0;
            if (m_phase == 0) begin
                if (req_valid) begin
                    m_phase = 1; m_cnt = WAIT_N; m_addr = req_addr; m_byte = req_byte;
                end
            end else if (m_phase == 1) begin
                if (m_cnt == 1) begin
                    w = rom_word(m_addr[19:1]);
                    e_valid = 1'b1;
                    e_data  = m_byte ? {8'h00, (m_addr[0] ? w[15:8] : w[7:0])} : w;
                    if (m_accept) begin
                        m_cnt = WAIT_N; m_addr = req_addr;
                    end else begin
                        m_phase = 2; m_cnt = TA_N;
                    end
                end else m_cnt = m_cnt - 1;
            end else begin
                if (m_cnt == 1) m_phase = 0;
                else m_cnt = m_cnt - 1;
            end
        end
    end

    int n_cmp = 0;
    int n_bad = 0;

    task automatic cmp(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string tg, rtg;
        if (!rst_n) begin
            cmp("R1", "ce_n", 32'(mem_ce_n), 32'd1);
            cmp("R1", "oe_n", 32'(mem_oe_n), 32'd1);
            cmp("R1", "lsb_oe", 32'(mem_lsb_oe), 32'd0);
            cmp("R1", "wide", 32'(mem_wide), 32'd1);
            cmp("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
            cmp("R1", "rsp_data", 32'(rsp_data), 32'd0);
            cmp("R1", "ready", 32'(req_ready), 32'd1);
            return;
        end
        cmp("R2", "ce_n", 32'(mem_ce_n), 32'(m_phase != 1));
        cmp("R2", "oe_n", 32'(mem_oe_n), 32'(m_phase != 1));
        if (m_phase == 0) rtg = "R10";
        else if (m_phase == 2) rtg = "R6";
        else if (m_cnt == 1 && req_byte != m_byte) rtg = "R8";
        else rtg = "R7";
        cmp(rtg, "ready", 32'(req_ready), 32'(model_ready()));
        cmp("R9", "lsb_oe", 32'(mem_lsb_oe), 32'(m_phase == 1 && m_byte));
        tg = m_byte ? "R4" : "R3";
        cmp(tg, "wide", 32'(mem_wide), 32'(!m_byte));
        cmp("R5", "rsp_valid", 32'(rsp_valid), 32'(e_valid));
        cmp("R5", "rsp_data", 32'(rsp_data), 32'(e_data));
        if (m_phase == 1) begin
            cmp(tg, "mem_addr", 32'(mem_addr), 32'(m_addr[19:1]));
            if (m_byte) cmp("R4", "lsb", 32'(mem_lsb), 32'(m_addr[0]));
        end
    endtask

    logic [19:0] q_addr [NREQ_MAX];
    logic        q_byte [NREQ_MAX];
    int          q_gap  [NREQ_MAX];
    int          nreq = 0;

    task automatic add(input logic [19:0] a, input logic b, input int g);
        q_addr[nreq] = a; q_byte[nreq] = b; q_gap[nreq] = g; nreq++;
    endtask

    initial begin
        int idx, gapc, cyc, tail;
        bit hung;
        add(20'h00000, 1'b0, 2);   // word at zero (R3)
        add(20'h00011, 1'b0, 0);   // odd word address, bit 0 ignored (R3)
        add(20'h00012, 1'b0, 0);   // chained word (R7)
        add(20'h00021, 1'b1, 0);   // size flip to byte, odd lane (R8, R4)
        add(20'h00020, 1'b1, 0);   // chained byte, even lane (R7)
        add(20'hFFFFF, 1'b1, 0);   // top byte address
        add(20'hFFFFE, 1'b0, 0);   // top word address, flip back (R8)
        add(20'h12345, 1'b1, 5);
        add(20'h54320, 1'b0, 3);
        add(20'h0ABCD, 1'b0, 0);
        add(20'h0ABCD, 1'b1, 0);
        add(20'h33333, 1'b1, 0);
        add(20'h33332, 1'b0, 7);
        for (int i = 1; i <= 16; i++)
            add(20'(i * 32'h1F3A7), 1'(i % 3 == 0), i % 4);

        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            compare_all();   // R1 reset state
        end
        rst_n = 1'b1;
        idx = 0; gapc = q_gap[0]; cyc = 0; tail = 0; hung = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin hung = 1; break; end
            if (m_accept) begin
                idx++;
                if (idx < nreq) gapc = q_gap[idx];
            end
            compare_all();
            if (idx >= nreq) begin
                req_valid = 1'b0;
                if (m_phase == 0) tail++;
                if (tail > 4) break;
            end else if (gapc > 0) begin
                req_valid = 1'b0;
                req_byte  = q_byte[idx];
                gapc--;
            end else begin
                req_valid = 1'b1;
                req_addr  = q_addr[idx];
                req_byte  = q_byte[idx];
            end
        end
        if (hung) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule